// File: doc/BRIEF.md
# Byte-Wide Timer and Interrupt Register Bank

This block is a sixteen-entry, byte-wide peripheral register bank of the kind that sits beside a small CPU. It holds two general ports with their direction bytes, a shift-register byte, an auxiliary-control byte, a peripheral-control byte and a second port-A byte. The register index is decoded from four address bits. Two 16-bit down-counters are mapped into the bank. Each counter advances only on cycles where the tick-enable input is high.

Timer 1 has a 16-bit latch. In free-running mode it counts from the loaded value down through 0xFFFF and then reloads from the latch, so one period is latch+2 ticks. Timer 2 is loaded directly from the bus and raises its flag once per load. An interrupt-flag byte and an interrupt-enable byte produce one registered interrupt line. Reading or writing certain registers has side effects on the flags, and the enable byte is written through a set/clear selector in bit 7.

Top module: `tib_regbank`

## Requirements
- R1: After synchronous reset, every storage byte reads 0x00. The timer 1 latch and counter read 0xFFFF, the timer 2 latch is 0x00 and the timer 2 counter reads 0xFFFF. The flag byte reads 0x00, the enable byte reads 0x80 and irq is low.
- R2: The register index is addr[12:9]; the lower address bits are ignored. Indices 0,1,2,3,10,11,12,15 are plain bytes that return the last value written.
- R3: A write to index 4 or 6 changes only the low byte of the timer 1 latch (read at index 6). The timer 1 counter is left unchanged.
- R4: A write to index 5 sets the high latch byte, loads the counter with the whole new latch and clears flag bit 6. The counter reads at index 4 (low byte) and index 5 (high byte).
- R5: A write to index 7 sets the high latch byte (read at index 7) and clears flag bit 6. It does not load the counter.
- R6: When aux-control (index 11) bits [7:6] equal 01, each tick decrements timer 1. The tick that takes it from 0x0000 to 0xFFFF sets flag bit 6, and the tick from 0xFFFF loads the latch, so successive flags are latch+2 ticks apart.
- R7: With any other aux-control mode, timer 1 never reloads and never sets flag bit 6. It decrements and wraps from 0xFFFF to 0xFFFE.
- R8: A write to index 8 stores the timer 2 low latch and loads the counter with {0x00, byte}. A write to index 9 loads the counter with {byte, low latch}. Each tick decrements the counter. Flag bit 5 is set on the first pass from 0x0000 to 0xFFFF after a load and not again until the next load.
- R9: Neither counter changes on a cycle where tick_en is low and no load write occurs.
- R10: A read of index 4 clears flag bit 6 and a read of index 8 clears flag bit 5. Reads of indices 5, 9 and 13 leave the flags unchanged.
- R11: A write to index 13 clears each flag bit written as 1. A read of index 13 returns the flags in bits [6:0], with bit 7 set when any flag is both set and enabled.
- R12: A write to index 14 with bit 7 set ORs bits [6:0] into the enables; with bit 7 clear, the 1 bits clear enables. A read of index 14 always returns bit 7 as 1.
- R13: irq is high exactly when flags AND enables is nonzero in bit 6 or bit 2. It changes on the same clock edge as the flags, and an enabled flag bit 5 alone never raises it.
- R14: When a timer sets its flag in the same cycle as an access that clears that flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address; the index is bits [IDX_LSB+3:IDX_LSB] |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; read side effects apply at the clock edge |
| wdata | input | DATA_W | Write data |
| tick_en | input | 1 | Counter advance enable |
| rdata | output | DATA_W | Combinational read data for the addressed index |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its defaults: ADDR_W of 13, IDX_LSB of 9 and DATA_W of 8. Because of these values, the index sits in addr[12:9] and every access can carry nonzero low address bits to show they are ignored. The 8-bit data width gives 16-bit counters. Small latch values make a full free-running period only a few ticks long, so the latch+2 spacing can be measured directly. The 16-bit timer 2 width keeps a full wrap of about 65k ticks within the run time, so the one-shot rule can be tested over a whole second pass through zero.

// File: rtl/tib_pkg.sv
`timescale 1ns/1ps
package tib_pkg;
  typedef enum logic [3:0] {
    IX_PORT_B   = 4'd0,
    IX_PORT_A   = 4'd1,
    IX_DIR_B    = 4'd2,
    IX_DIR_A    = 4'd3,
    IX_T1_CNT_L = 4'd4,
    IX_T1_CNT_H = 4'd5,
    IX_T1_LAT_L = 4'd6,
    IX_T1_LAT_H = 4'd7,
    IX_T2_L     = 4'd8,
    IX_T2_H     = 4'd9,
    IX_SHIFT    = 4'd10,
    IX_AUX      = 4'd11,
    IX_PCTL     = 4'd12,
    IX_FLAGS    = 4'd13,
    IX_ENABLES  = 4'd14,
    IX_PA_RAW   = 4'd15
  } reg_idx_e;

  localparam int NUM_IDX = 16;
  localparam int IDX_W   = 4;

  // indices backed by a plain storage byte
  localparam logic [NUM_IDX-1:0] PLAIN_MAP = 16'b1001_1100_0000_1111;

  // flag bit positions
  localparam int FLG_SR = 2;
  localparam int FLG_T2 = 5;
  localparam int FLG_T1 = 6;

  // aux-control bits [7:6] selecting free-running timer 1
  localparam logic [1:0] T1_FREE_RUN = 2'b01;
endpackage

// File: rtl/tib_timer1.sv
`timescale 1ns/1ps
module tib_timer1 #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            free_run,
  input  logic            lo_we,
  input  logic            hi_we,
  input  logic            load,
  input  logic [DW-1:0]   wbyte,
  output logic [2*DW-1:0] latch,
  output logic [2*DW-1:0] count,
  output logic            expire
);
  localparam int CW = 2 * DW;

  logic at_zero, at_top;
  assign at_zero = (count == '0);
  assign at_top  = (count == {CW{1'b1}});
  assign expire  = tick && !load && free_run && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch <= {CW{1'b1}};
    end else begin
      if (lo_we) latch[DW-1:0]  <= wbyte;
      if (hi_we) latch[CW-1:DW] <= wbyte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= {CW{1'b1}};
    end else if (load) begin
      count <= {wbyte, latch[DW-1:0]};
    end else if (tick) begin
      if (free_run && at_top) count <= latch;
      else                    count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/tib_timer2.sv
`timescale 1ns/1ps
module tib_timer2 #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            lo_we,
  input  logic            hi_we,
  input  logic [DW-1:0]   wbyte,
  output logic [2*DW-1:0] count,
  output logic            expire
);
  localparam int CW = 2 * DW;

  logic [DW-1:0] lat_lo;
  logic          armed;
  logic          load;

  assign load   = lo_we || hi_we;
  assign expire = tick && !load && armed && (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_lo <= '0;
      count  <= {CW{1'b1}};
      armed  <= 1'b0;
    end else if (lo_we) begin
      lat_lo <= wbyte;
      count  <= {{DW{1'b0}}, wbyte};
      armed  <= 1'b1;
    end else if (hi_we) begin
      count  <= {wbyte, lat_lo};
      armed  <= 1'b1;
    end else if (tick) begin
      count <= count - 1'b1;
      if (expire) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/tib_irq.sv
`timescale 1ns/1ps
module tib_irq
  import tib_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-2:0] set_mask,
  input  logic [DW-2:0] clr_mask,
  input  logic          ier_we,
  input  logic [DW-1:0] wbyte,
  output logic [DW-2:0] flags,
  output logic [DW-2:0] ier,
  output logic          irq
);
  localparam int FW = DW - 1;
  localparam logic [FW-1:0] IRQ_SRC = FW'((1 << FLG_SR) | (1 << FLG_T1));

  logic [FW-1:0] flags_n, ier_n;

  always_comb begin
    // a set in the same cycle as a clear wins
    flags_n = (flags & ~clr_mask) | set_mask;
    ier_n   = ier;
    if (ier_we) begin
      if (wbyte[DW-1]) ier_n = ier | wbyte[FW-1:0];
      else             ier_n = ier & ~wbyte[FW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      ier   <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= flags_n;
      ier   <= ier_n;
      irq   <= |(flags_n & ier_n & IRQ_SRC);
    end
  end
endmodule

// File: rtl/tib_regbank.sv
`timescale 1ns/1ps
module tib_regbank
  import tib_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int IDX_LSB = 9,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick_en,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int CW = 2 * DATA_W;
  localparam int FW = DATA_W - 1;

  logic [IDX_W-1:0] idx;
  logic             unused_addr_bits;
  assign idx              = addr[IDX_LSB +: IDX_W];
  assign unused_addr_bits = ^addr;

  function automatic logic hit(input logic [IDX_W-1:0] a, input reg_idx_e b);
    return a == IDX_W'(b);
  endfunction

  // plain storage bytes
  logic [DATA_W-1:0] plain_rd [NUM_IDX];

  for (genvar g = 0; g < NUM_IDX; g++) begin : g_plain
    if (PLAIN_MAP[g]) begin : g_keep
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                              q <= '0;
        else if (wr_en && idx == IDX_W'(g))   q <= wdata;
      end
      assign plain_rd[g] = q;
    end else begin : g_none
      assign plain_rd[g] = '0;
    end
  end

  logic [DATA_W-1:0] aux_q;
  logic              t1_free;
  assign aux_q   = plain_rd[IX_AUX];
  assign t1_free = (aux_q[DATA_W-1 -: 2] == T1_FREE_RUN);

  // timer 1
  logic [CW-1:0] t1_lat, t1_cnt;
  logic          t1_exp;

  tib_timer1 #(.DW(DATA_W)) u_t1 (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_en),
    .free_run (t1_free),
    .lo_we    (wr_en && (hit(idx, IX_T1_CNT_L) || hit(idx, IX_T1_LAT_L))),
    .hi_we    (wr_en && (hit(idx, IX_T1_CNT_H) || hit(idx, IX_T1_LAT_H))),
    .load     (wr_en && hit(idx, IX_T1_CNT_H)),
    .wbyte    (wdata),
    .latch    (t1_lat),
    .count    (t1_cnt),
    .expire   (t1_exp)
  );

  // timer 2
  logic [CW-1:0] t2_cnt;
  logic          t2_exp;

  tib_timer2 #(.DW(DATA_W)) u_t2 (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick_en),
    .lo_we  (wr_en && hit(idx, IX_T2_L)),
    .hi_we  (wr_en && hit(idx, IX_T2_H)),
    .wbyte  (wdata),
    .count  (t2_cnt),
    .expire (t2_exp)
  );

  // flag set and clear sources
  logic [FW-1:0] set_mask, clr_mask, flags, ier;

  always_comb begin
    set_mask = '0;
    set_mask[FLG_T1] = t1_exp;
    set_mask[FLG_T2] = t2_exp;

    clr_mask = '0;
    if (wr_en && hit(idx, IX_FLAGS)) clr_mask = wdata[FW-1:0];
    if ((wr_en && (hit(idx, IX_T1_CNT_H) || hit(idx, IX_T1_LAT_H))) ||
        (rd_en && hit(idx, IX_T1_CNT_L)))
      clr_mask[FLG_T1] = 1'b1;
    if (rd_en && hit(idx, IX_T2_L))
      clr_mask[FLG_T2] = 1'b1;
  end

  tib_irq #(.DW(DATA_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .ier_we   (wr_en && hit(idx, IX_ENABLES)),
    .wbyte    (wdata),
    .flags    (flags),
    .ier      (ier),
    .irq      (irq)
  );

  // read mux
  always_comb begin
    unique case (idx)
      IDX_W'(IX_T1_CNT_L): rdata = t1_cnt[DATA_W-1:0];
      IDX_W'(IX_T1_CNT_H): rdata = t1_cnt[CW-1:DATA_W];
      IDX_W'(IX_T1_LAT_L): rdata = t1_lat[DATA_W-1:0];
      IDX_W'(IX_T1_LAT_H): rdata = t1_lat[CW-1:DATA_W];
      IDX_W'(IX_T2_L):     rdata = t2_cnt[DATA_W-1:0];
      IDX_W'(IX_T2_H):     rdata = t2_cnt[CW-1:DATA_W];
      IDX_W'(IX_FLAGS):    rdata = {|(flags & ier), flags};
      IDX_W'(IX_ENABLES):  rdata = {1'b1, ier};
      default:             rdata = plain_rd[idx];
    endcase
  end
endmodule

// File: rtl/tib_regbank_chk.sv
`timescale 1ns/1ps
module tib_regbank_chk #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                rd_en,
  input logic                tick_en,
  input logic [3:0]          idx,
  input logic [DATA_W-1:0]   wdata,
  input logic [DATA_W-1:0]   rdata,
  input logic                irq,
  input logic                t1_free,
  input logic [2*DATA_W-1:0] t1_lat,
  input logic [2*DATA_W-1:0] t1_cnt,
  input logic [2*DATA_W-1:0] t2_cnt,
  input logic [DATA_W-2:0]   flags,
  input logic [DATA_W-2:0]   ier
);
  AST_T1_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == 4'd5) |=> t1_cnt == {$past(wdata), $past(t1_lat[DATA_W-1:0])}); // R4

  AST_T1_LOAD_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == 4'd5) |=> !flags[6]); // R4

  AST_T1_RELOAD_FROM_LATCH: assert property (@(posedge clk) disable iff (rst)
    (tick_en && t1_free && !wr_en && t1_cnt == '1) |=> t1_cnt == $past(t1_lat)); // R6

  AST_COUNTERS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !wr_en) |=> ($stable(t1_cnt) && $stable(t2_cnt))); // R9

  AST_ENABLE_READ_TOP_BIT: assert property (@(posedge clk) disable iff (rst)
    (rd_en && idx == 4'd14) |-> rdata[DATA_W-1]); // R12

  AST_IRQ_FROM_T1: assert property (@(posedge clk) disable iff (rst)
    (flags[6] && ier[6]) |-> irq); // R13

  AST_IRQ_NOT_FROM_T2: assert property (@(posedge clk) disable iff (rst)
    (!(flags[6] && ier[6]) && !(flags[2] && ier[2])) |-> !irq); // R13
endmodule

bind tib_regbank tib_regbank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .tick_en (tick_en),
  .idx     (idx),
  .wdata   (wdata),
  .rdata   (rdata),
  .irq     (irq),
  .t1_free (t1_free),
  .t1_lat  (t1_lat),
  .t1_cnt  (t1_cnt),
  .t2_cnt  (t2_cnt),
  .flags   (flags),
  .ier     (ier)
);

// File: tb/tib_regbank_tb.sv
`timescale 1ns/1ps
module tib_regbank_tb_top;
  localparam int ADDR_W  = 13;
  localparam int IDX_LSB = 9;
  localparam int DATA_W  = 8;
  localparam int WATCHDOG_CYCLES = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [DATA_W-1:0] wdata = '0;
  logic              tick_en = 1'b0;
  logic [DATA_W-1:0] rdata;
  logic              irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tib_regbank #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .tick_en(tick_en), .rdata(rdata), .irq(irq)
  );

  function automatic logic [ADDR_W-1:0] mk_addr(input int ix);
    return (ADDR_W'(ix) << IDX_LSB) | ADDR_W'(13'h0A5);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int ix, input logic [7:0] v);
    @(negedge clk);
    addr = mk_addr(ix); wdata = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ix, output logic [7:0] v);
    @(negedge clk);
    addr = mk_addr(ix); rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int ix, input logic [7:0] exp);
    logic [7:0] v;
    rd(ix, v);
    check(req, $sformatf("index %0d", ix), 16'(v), 16'(exp));
  endtask

  // reads high byte first; the low-byte read clears the timer 1 flag
  task automatic t1_chk(input string req, input logic [15:0] exp);
    logic [7:0] h, l;
    rd(5, h); rd(4, l);
    check(req, "timer1 counter", {h, l}, exp);
  endtask

  task automatic t2_chk(input string req, input logic [15:0] exp);
    logic [7:0] h, l;
    rd(9, h); rd(8, l);
    check(req, "timer2 counter", {h, l}, exp);
  endtask

  task automatic irq_chk(input string req, input logic exp);
    @(negedge clk);
    check(req, "irq", 16'(irq), 16'(exp));
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset();
    irq_chk("R1", 1'b0);
    foreach (tib_pkg::PLAIN_MAP[i]) if (tib_pkg::PLAIN_MAP[i]) rd_chk("R1", i, 8'h00);
    t1_chk("R1", 16'hFFFF);
    rd_chk("R1", 6, 8'hFF);
    rd_chk("R1", 7, 8'hFF);
    rd_chk("R1", 9, 8'hFF);
    rd_chk("R1", 8, 8'hFF);
    rd_chk("R1", 13, 8'h00);
    rd_chk("R1", 14, 8'h80);
  endtask

  task automatic t_plain();
    for (int i = 0; i < 16; i++) if (tib_pkg::PLAIN_MAP[i]) wr(i, 8'(i * 37 + 1));
    for (int i = 0; i < 16; i++) if (tib_pkg::PLAIN_MAP[i]) rd_chk("R2", i, 8'(i * 37 + 1));
  endtask

  task automatic t_t1_latch();
    wr(4, 8'h34);
    rd_chk("R3", 6, 8'h34);
    t1_chk("R3", 16'hFFFF);
    wr(6, 8'h12);
    rd_chk("R3", 6, 8'h12);
    wr(7, 8'h56);
    rd_chk("R5", 7, 8'h56);
    t1_chk("R5", 16'hFFFF);
    wr(5, 8'h00);
    rd_chk("R4", 7, 8'h00);
    rd_chk("R4", 6, 8'h12);
    t1_chk("R4", 16'h0012);
  endtask

  task automatic t_t1_free();
    logic [7:0] v;
    wr(11, 8'h40);
    wr(14, 8'h7F);
    wr(14, 8'hC0);
    wr(6, 8'h03);
    wr(5, 8'h00);
    ticks(3);
    rd_chk("R6", 13, 8'h00);
    irq_chk("R13", 1'b0);
    ticks(1);
    irq_chk("R13", 1'b1);
    rd_chk("R6", 13, 8'hC0);
    ticks(1);
    rd_chk("R6", 5, 8'h00);
    rd_chk("R10", 13, 8'hC0);
    rd_chk("R6", 4, 8'h03);
    rd_chk("R10", 13, 8'h00);
    irq_chk("R13", 1'b0);
    // period check: latch+2 = 5 ticks between flag sets
    ticks(3);
    rd_chk("R6", 13, 8'h00);
    ticks(1);
    rd_chk("R6", 13, 8'hC0);
    wr(7, 8'h00);
    rd_chk("R5", 13, 8'h00);
    t1_chk("R5", 16'hFFFF);
    // same-cycle flag set and low-byte read
    wr(6, 8'h01);
    wr(5, 8'h00);
    ticks(1);
    @(negedge clk);
    addr = mk_addr(4); rd_en = 1'b1; tick_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0; tick_en = 1'b0;
    check("R14", "counter low at race", 16'(v), 16'h0000);
    rd_chk("R14", 13, 8'hC0);
    wr(13, 8'h40);
    rd_chk("R11", 13, 8'h00);
    irq_chk("R13", 1'b0);
  endtask

  task automatic t_t1_stop();
    wr(11, 8'h80);
    wr(6, 8'h02);
    wr(5, 8'h00);
    ticks(3);
    rd_chk("R7", 13, 8'h00);
    ticks(1);
    t1_chk("R7", 16'hFFFE);
    rd_chk("R7", 13, 8'h00);
    repeat (6) @(negedge clk);
    t1_chk("R9", 16'hFFFE);
  endtask

  task automatic t_t2();
    wr(14, 8'h7F);
    wr(14, 8'hA0);
    wr(8, 8'h02);
    t2_chk("R8", 16'h0002);
    ticks(2);
    rd_chk("R8", 13, 8'h00);
    ticks(1);
    rd_chk("R11", 13, 8'hA0);
    irq_chk("R13", 1'b0);
    ticks(3);
    rd_chk("R10", 9, 8'hFF);
    rd_chk("R10", 13, 8'hA0);
    wr(13, 8'h20);
    rd_chk("R11", 13, 8'h00);
    // second pass through zero without a reload: no flag
    ticks(65533);
    rd_chk("R8", 13, 8'h00);
    rd_chk("R8", 9, 8'hFF);
    wr(9, 8'h01);
    rd_chk("R8", 9, 8'h01);
    wr(9, 8'h00);
    ticks(3);
    rd_chk("R8", 13, 8'hA0);
    rd_chk("R10", 8, 8'hFF);
    rd_chk("R10", 13, 8'h00);
  endtask

  task automatic t_mixed();
    wr(11, 8'h40);
    wr(6, 8'h00);
    wr(5, 8'h00);
    wr(9, 8'h00);
    ticks(3);
    rd_chk("R11", 13, 8'hE0);
    wr(13, 8'h20);
    rd_chk("R11", 13, 8'h40);
    irq_chk("R13", 1'b0);
    wr(14, 8'hC0);
    irq_chk("R13", 1'b1);
    wr(11, 8'h00);
    wr(14, 8'h7F);
    irq_chk("R13", 1'b0);
  endtask

  task automatic t_enables();
    rd_chk("R12", 14, 8'h80);
    wr(14, 8'h85);
    rd_chk("R12", 14, 8'h85);
    wr(14, 8'h81);
    rd_chk("R12", 14, 8'h85);
    wr(14, 8'h04);
    rd_chk("R12", 14, 8'h81);
    wr(14, 8'h01);
    rd_chk("R12", 14, 8'h80);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_plain();
    t_t1_latch();
    t_t1_free();
    t_t1_stop();
    t_t2();
    t_mixed();
    t_enables();
    finish_run();
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule